// File: doc/BRIEF.md
# Saturating multiply-accumulate word unit

This block multiplies two signed 16-bit operands and adds the product into a split accumulator. The accumulator is a high word (`mach_o`) and a 32-bit low word (`macl_o`). The caller reads the operands from memory and presents them, together with the two pointers they came from, on a single accumulate strobe. The unit advances both pointers by two and returns them one clock later, ready for the next fetch.

A mode input picks one of two accumulation modes:

- **Saturating mode.** The low word acts as a 32-bit signed accumulator. It clamps on signed overflow, and bit 0 of the high word records that overflow and stays set.
- **Wide mode.** The high word takes the product's sign extension plus the carry out of the low word. The high word is then trimmed to a 10-bit signed value, which gives a 42-bit running sum.

A side port can clear the accumulator or load either word directly.

Top module: `mac_word_unit`

## Requirements
- R1: On an accumulate, `opa_i` and `opb_i` are each taken as signed 16-bit values. Their product is a signed 32-bit value, sign-extended before it is added. With the accumulator cleared and wide mode selected, `macl_o` becomes the product and `mach_o` becomes all ones for a negative product, or zero otherwise.
- R2: Each cycle with `acc_valid_i` high registers `ptra_i + 2` and `ptrb_i + 2` on `ptra_o` and `ptrb_o`. It also raises `ptr_valid_o` in the next cycle. This holds even when a clear or a load takes priority over the accumulation.
- R3: In saturating mode (`sat_mode_i` = 1), overflow means the product and `macl_o` have the same sign bit and the 32-bit sum has the other sign. On overflow, `macl_o` becomes 0x80000000 for a negative product and 0x7FFFFFFF otherwise.
- R4: In saturating mode, an overflow sets bit 0 of `mach_o` and leaves its other bits as they were. Once set, that bit stays set through later saturating accumulates.
- R5: In saturating mode without overflow, `macl_o` receives the 32-bit wrapped sum and `mach_o` is left unchanged.
- R6: In wide mode (`sat_mode_i` = 0), `macl_o` receives the low 32 bits of the unsigned sum. `mach_o` becomes `mach_o` plus the product's sign extension (all ones when negative) plus that sum's carry out, kept to 10 bits and sign-extended from bit 9.
- R7: `clear_i` zeroes both accumulator words in one clock. It has priority over loads and accumulates in the same cycle.
- R8: `load_hi_i` writes `load_data_i` to `mach_o` and `load_lo_i` writes it to `macl_o`. Both may be high in the same cycle. A load has priority over an accumulate and yields to a clear.
- R9: Asynchronous reset zeroes both accumulator words and both pointer outputs, and drops `ptr_valid_o`.
- R10: In a cycle with no strobe, clear or load, every output except `ptr_valid_o` keeps its value, and `ptr_valid_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sat_mode_i | input | 1 | 1 = saturating 32-bit mode, 0 = wide mode |
| acc_valid_i | input | 1 | Accumulate strobe |
| opa_i | input | 16 | First operand, signed |
| opb_i | input | 16 | Second operand, signed |
| ptra_i | input | 32 | Pointer of the first operand |
| ptrb_i | input | 32 | Pointer of the second operand |
| clear_i | input | 1 | Zero both accumulator words |
| load_hi_i | input | 1 | Write `load_data_i` to the high word |
| load_lo_i | input | 1 | Write `load_data_i` to the low word |
| load_data_i | input | 32 | Load value |
| mach_o | output | 32 | High accumulator word |
| macl_o | output | 32 | Low accumulator word |
| ptra_o | output | 32 | Advanced first pointer |
| ptrb_o | output | 32 | Advanced second pointer |
| ptr_valid_o | output | 1 | Advanced pointers valid |

## Verification
The assertions on the high word assume that `sat_mode_i` is stable over the cycle that uses it. They also assume that the sticky bit and the 10-bit sign extension are only judged after an accumulate that no clear or load overrode. The bench drives every input once per cycle away from the rising edge, so the mode is never ambiguous at a sampling edge. Directed cases load the words before each overflow or carry scenario so that each case starts from a known state. Random phases mix modes, loads, clears and extreme operands, and the model in the bench tracks every combination, including mode switches between strobes.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MAC_IDLE = 2'd0,
    MAC_CLR  = 2'd1,
    MAC_LOAD = 2'd2,
    MAC_ACC  = 2'd3
  } mac_cmd_e;

  // clear > load > accumulate
  function automatic mac_cmd_e mac_decode(input logic clr, input logic ld, input logic acc);
    if (clr)      return MAC_CLR;
    else if (ld)  return MAC_LOAD;
    else if (acc) return MAC_ACC;
    else          return MAC_IDLE;
  endfunction

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OP_W   = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]          a_i,
  input  logic [OP_W-1:0]          b_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_x, b_x;
  assign a_x    = PROD_W'($signed(a_i));
  assign b_x    = PROD_W'($signed(b_i));
  assign prod_o = a_x * b_x;
endmodule

// File: rtl/mac_sat_path.sv
module mac_sat_path #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic [ACC_W-1:0]         hi_i,
  input  logic [ACC_W-1:0]         lo_i,
  output logic [ACC_W-1:0]         hi_o,
  output logic [ACC_W-1:0]         lo_o,
  output logic                     ovf_o
);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] prod_x, sum;
  logic             neg;

  assign prod_x = ACC_W'(prod_i);
  assign neg    = prod_x[ACC_W-1];
  assign sum    = lo_i + prod_x;
  // same-sign operands, different-sign result
  assign ovf_o  = (neg == lo_i[ACC_W-1]) && (sum[ACC_W-1] != neg);
  assign lo_o   = ovf_o ? (neg ? NEG_MIN : POS_MAX) : sum;
  assign hi_o   = ovf_o ? (hi_i | ACC_W'(1)) : hi_i;
endmodule

// File: rtl/mac_wide_path.sv
module mac_wide_path #(
  parameter int PROD_W  = 32,
  parameter int ACC_W   = 32,
  parameter int HI_KEEP = 10
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic [HI_KEEP-1:0]       hi_i,
  input  logic [ACC_W-1:0]         lo_i,
  output logic [ACC_W-1:0]         hi_o,
  output logic [ACC_W-1:0]         lo_o
);
  logic [ACC_W-1:0]   prod_x;
  logic [ACC_W:0]     wsum;
  logic [HI_KEEP-1:0] hi_t;

  assign prod_x = ACC_W'(prod_i);
  assign wsum   = {1'b0, lo_i} + {1'b0, prod_x};
  assign lo_o   = wsum[ACC_W-1:0];
  // only the kept bits matter: upper bits are rebuilt from bit HI_KEEP-1
  assign hi_t   = hi_i + {HI_KEEP{prod_x[ACC_W-1]}} + HI_KEEP'(wsum[ACC_W]);
  assign hi_o   = {{(ACC_W-HI_KEEP){hi_t[HI_KEEP-1]}}, hi_t};
endmodule

// File: rtl/mac_word_unit.sv
module mac_word_unit #(
  parameter int OP_W     = 16,
  parameter int ACC_W    = 32,
  parameter int HI_KEEP  = 10,
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sat_mode_i,
  input  logic             acc_valid_i,
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  input  logic [PTR_W-1:0] ptra_i,
  input  logic [PTR_W-1:0] ptrb_i,
  input  logic             clear_i,
  input  logic             load_hi_i,
  input  logic             load_lo_i,
  input  logic [ACC_W-1:0] load_data_i,
  output logic [ACC_W-1:0] mach_o,
  output logic [ACC_W-1:0] macl_o,
  output logic [PTR_W-1:0] ptra_o,
  output logic [PTR_W-1:0] ptrb_o,
  output logic             ptr_valid_o
);
  import mac_pkg::*;

  localparam int PROD_W = 2 * OP_W;
  localparam int NPTR   = 2;
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0] mach_q, macl_q;
  logic [ACC_W-1:0] sat_hi, sat_lo, wide_hi, wide_lo, nxt_hi, nxt_lo;
  logic             sat_ovf;
  mac_cmd_e         cmd;

  logic [PTR_W-1:0] ptr_in [NPTR];
  logic [PTR_W-1:0] ptr_q  [NPTR];
  logic             pv_q;

  mac_mul #(.OP_W(OP_W)) mul_i (
    .a_i(opa_i), .b_i(opb_i), .prod_o(prod)
  );

  mac_sat_path #(.PROD_W(PROD_W), .ACC_W(ACC_W)) sat_i (
    .prod_i(prod), .hi_i(mach_q), .lo_i(macl_q),
    .hi_o(sat_hi), .lo_o(sat_lo), .ovf_o(sat_ovf)
  );

  mac_wide_path #(.PROD_W(PROD_W), .ACC_W(ACC_W), .HI_KEEP(HI_KEEP)) wide_i (
    .prod_i(prod), .hi_i(mach_q[HI_KEEP-1:0]), .lo_i(macl_q),
    .hi_o(wide_hi), .lo_o(wide_lo)
  );

  assign cmd    = mac_decode(clear_i, load_hi_i | load_lo_i, acc_valid_i);
  assign nxt_hi = sat_mode_i ? sat_hi : wide_hi;
  assign nxt_lo = sat_mode_i ? sat_lo : wide_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mach_q <= '0;
      macl_q <= '0;
    end else begin
      unique case (cmd)
        MAC_CLR: begin
          mach_q <= '0;
          macl_q <= '0;
        end
        MAC_LOAD: begin
          if (load_hi_i) mach_q <= load_data_i;
          if (load_lo_i) macl_q <= load_data_i;
        end
        MAC_ACC: begin
          mach_q <= nxt_hi;
          macl_q <= nxt_lo;
        end
        default: ;
      endcase
    end
  end

  assign ptr_in[0] = ptra_i;
  assign ptr_in[1] = ptrb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
      pv_q <= 1'b0;
    end else begin
      pv_q <= acc_valid_i;
      if (acc_valid_i)
        for (int i = 0; i < NPTR; i++) ptr_q[i] <= ptr_in[i] + PTR_W'(PTR_STEP);
    end
  end

  assign mach_o      = mach_q;
  assign macl_o      = macl_q;
  assign ptra_o      = ptr_q[0];
  assign ptrb_o      = ptr_q[1];
  assign ptr_valid_o = pv_q;

  logic acc_win;
  assign acc_win = (cmd == MAC_ACC);

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mach_o == '0 && macl_o == '0));

  // R2
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr_chk
    ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_valid_i |=> (ptr_q[g] == $past(ptr_in[g]) + PTR_W'(PTR_STEP)));
  end

  // R3
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_win && sat_mode_i && sat_ovf) |=> (macl_o == POS_MAX || macl_o == NEG_MIN));

  // R4
  sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_win && sat_mode_i && (mach_o[0] || sat_ovf)) |=> mach_o[0]);

  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_win && sat_mode_i && !sat_ovf) |=> $stable(mach_o));

  // R6
  wide_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_win && !sat_mode_i) |=>
      ((&mach_o[ACC_W-1:HI_KEEP-1]) || !(|mach_o[ACC_W-1:HI_KEEP-1])));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == MAC_IDLE) |=> ($stable(mach_o) && $stable(macl_o) && $stable(ptra_o)
                           && $stable(ptrb_o) && !ptr_valid_o));

endmodule

// File: tb/mac_word_unit_tb_top.sv
`timescale 1ns/1ps
module mac_word_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sat_mode_i = 1'b0, acc_valid_i = 1'b0, clear_i = 1'b0;
  logic        load_hi_i = 1'b0, load_lo_i = 1'b0;
  logic [15:0] opa_i = '0, opb_i = '0;
  logic [31:0] ptra_i = '0, ptrb_i = '0, load_data_i = '0;
  logic [31:0] mach_o, macl_o, ptra_o, ptrb_o;
  logic        ptr_valid_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] e_hi = '0, e_lo = '0, e_pa = '0, e_pb = '0;
  logic        e_pv = 1'b0;

  always #2 clk_i = ~clk_i;

  mac_word_unit dut_i (
    .clk_i, .rst_ni, .sat_mode_i, .acc_valid_i, .opa_i, .opb_i,
    .ptra_i, .ptrb_i, .clear_i, .load_hi_i, .load_lo_i, .load_data_i,
    .mach_o, .macl_o, .ptra_o, .ptrb_o, .ptr_valid_o
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "mach", mach_o, e_hi);
    chk(tag, "macl", macl_o, e_lo);
    chk(tag, "ptra", ptra_o, e_pa);
    chk(tag, "ptrb", ptrb_o, e_pb);
    chk(tag, "pvld", {31'b0, ptr_valid_o}, {31'b0, e_pv});
  endtask

  // behavioural model of one clock
  task automatic model(bit v, bit s, bit clr, bit lh, bit ll, logic [31:0] d,
                       logic [15:0] a, logic [15:0] b, logic [31:0] pa, logic [31:0] pb);
    longint p, sm, u, m, cy;
    e_pv = v;
    if (v) begin
      e_pa = pa + 32'd2;
      e_pb = pb + 32'd2;
    end
    if (clr) begin
      e_hi = '0; e_lo = '0;
    end else if (lh || ll) begin
      if (lh) e_hi = d;
      if (ll) e_lo = d;
    end else if (v) begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (s) begin
        sm = longint'($signed(e_lo)) + p;
        if (sm > 64'sd2147483647 || sm < -64'sd2147483648) begin
          e_hi = e_hi | 32'd1;
          e_lo = (p < 0) ? 32'h8000_0000 : 32'h7fff_ffff;
        end else begin
          e_lo = sm[31:0];
        end
      end else begin
        u  = longint'({32'b0, e_lo}) + longint'({32'b0, p[31:0]});
        cy = (u >>> 32) & 64'sd1;
        m  = longint'($signed(e_hi)) + ((p < 0) ? -64'sd1 : 64'sd0) + cy;
        m  = m & 64'sd1023;
        if (m >= 64'sd512) m = m - 64'sd1024;
        e_hi = m[31:0];
        e_lo = u[31:0];
      end
    end
  endtask

  task automatic step(string tag, bit v, bit s, bit clr, bit lh, bit ll, logic [31:0] d,
                      logic [15:0] a, logic [15:0] b, logic [31:0] pa, logic [31:0] pb);
    acc_valid_i = v; sat_mode_i = s; clear_i = clr; load_hi_i = lh; load_lo_i = ll;
    load_data_i = d; opa_i = a; opb_i = b; ptra_i = pa; ptrb_i = pb;
    model(v, s, clr, lh, ll, d, a, b, pa, pb);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  task automatic load2(string tag, logic [31:0] hi, logic [31:0] lo);
    step(tag, 0, 0, 0, 1, 0, hi, '0, '0, '0, '0);
    step(tag, 0, 0, 0, 0, 1, lo, '0, '0, '0, '0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare_all("R9 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R9 after release");

    // R1 signed product, wide mode from zero
    step("R1 neg product", 1, 0, 0, 0, 0, '0, 16'd3, 16'hfffb, 32'h100, 32'h200);
    step("R7 clear", 0, 0, 1, 0, 0, '0, '0, '0, '0, '0);
    step("R1 min*min", 1, 0, 0, 0, 0, '0, 16'h8000, 16'h8000, 32'h104, 32'h204);
    step("R2 pointer wrap", 1, 0, 0, 0, 0, '0, 16'd1, 16'd1, 32'hffff_fffe, 32'h7fff_ffff);

    // R6 carry into high word, and 10-bit wrap
    load2("R8 load", 32'h0, 32'hffff_ffff);
    step("R6 carry", 1, 0, 0, 0, 0, '0, 16'd1, 16'd1, 32'h0, 32'h0);
    load2("R8 load", 32'h1ff, 32'hffff_ffff);
    step("R6 wrap bit9", 1, 0, 0, 0, 0, '0, 16'd1, 16'd1, 32'h10, 32'h20);
    load2("R8 load", 32'h1234_5678, 32'h0000_0005);
    step("R6 trim high", 1, 0, 0, 0, 0, '0, 16'hfffe, 16'd3, 32'h30, 32'h40);

    // R5 saturating without overflow keeps high word
    load2("R8 load", 32'hcafe_0000, 32'h0000_1000);
    step("R5 no ovf", 1, 1, 0, 0, 0, '0, 16'h7fff, 16'h0002, 32'h50, 32'h60);
    step("R5 no ovf neg", 1, 1, 0, 0, 0, '0, 16'h8000, 16'h0001, 32'h52, 32'h62);

    // R3 / R4 positive and negative saturation, sticky bit
    load2("R8 load", 32'h0, 32'h7fff_fff0);
    step("R3 pos sat", 1, 1, 0, 0, 0, '0, 16'h7fff, 16'h7fff, 32'h70, 32'h80);
    step("R4 sticky", 1, 1, 0, 0, 0, '0, 16'hffff, 16'h0001, 32'h72, 32'h82);
    load2("R8 load", 32'h0000_0100, 32'h8000_0010);
    step("R3 neg sat", 1, 1, 0, 0, 0, '0, 16'h8000, 16'h7fff, 32'h90, 32'ha0);
    step("R4 sticky keep", 1, 1, 0, 0, 0, '0, 16'h0010, 16'h0010, 32'h92, 32'ha2);

    // R7 clear beats load and accumulate; R8 load beats accumulate
    step("R7 clear priority", 1, 1, 1, 1, 1, 32'hdead_beef, 16'h7fff, 16'h7fff, 32'hb0, 32'hc0);
    step("R8 load both", 1, 0, 0, 1, 1, 32'h0bad_f00d, 16'h1234, 16'h4321, 32'hb2, 32'hc2);
    step("R8 load lo only", 1, 0, 0, 0, 1, 32'h0000_0042, 16'h7fff, 16'h7fff, 32'hb4, 32'hc4);

    // R10 idle ignores data inputs
    step("R10 idle", 0, 1, 0, 0, 0, 32'hffff_ffff, 16'h8000, 16'h8000, 32'h1234, 32'h5678);
    step("R10 idle", 0, 0, 0, 0, 0, 32'h5555_5555, 16'h7fff, 16'h8000, 32'h9999, 32'h7777);

    // mixed random traffic, extreme operands favoured
    for (int i = 0; i < 400; i++) begin
      bit v, s, clr, lh, ll;
      logic [15:0] a, b;
      logic [31:0] d;
      int r;
      r   = $urandom_range(0, 99);
      v   = (r < 80);
      s   = $urandom_range(0, 1);
      clr = ($urandom_range(0, 99) < 3);
      lh  = ($urandom_range(0, 99) < 5);
      ll  = ($urandom_range(0, 99) < 5);
      d   = $urandom;
      case ($urandom_range(0, 3))
        0: a = 16'h8000;
        1: a = 16'h7fff;
        default: a = 16'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: b = 16'h8000;
        1: b = 16'h7fff;
        default: b = 16'($urandom);
      endcase
      step("R3 R5 R6 mixed", v, s, clr, lh, ll, d, a, b, $urandom, $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule